// File: doc/BRIEF.md
# Keypad PIN Entry Checker

This block sits behind a 4x4 matrix keypad scanner. Every clock it sees the scanner's current decoded key: a 2-bit row index, a 2-bit column index and a valid flag. It turns each new press into a key symbol. Decimal digits go into a six-slot entry buffer. The '#' key submits the buffer for comparison with a fixed secret. A match LED shows the result of the latest submission.

The digits typed so far are always available as packed BCD nibbles with one enable flag per slot, so a seven-segment path can show the partial entry. Slot 0 holds the first digit typed. A key counts once per press, however long the scanner keeps reporting it. Letter and star keys have no effect.

Top module: `pin_entry_checker`

## Requirements
- R1: While reset is asserted, and after it is released, the LED is off, every display enable is 0 and every display nibble is 0.
- R2: Key symbols are mapped row by row. Row 0, columns 0..2 give the digits 1,2,3; row 1 gives 4,5,6; row 2 gives 7,8,9; row 3, column 1 is digit 0; row 3, column 2 is '#'. Column 3 holds the letters, and row 3, column 0 is '*'. A digit is stored as its 4-bit BCD value in nibble k (bits 4k+3..4k) of the display output, with k being the order of entry starting at 0.
- R3: A held key is registered once only: when valid rises from low, and not again while valid stays high with the same row and column.
- R4: If valid stays high while the row or column changes, the new key counts as a fresh press.
- R5: An accepted digit appears on the clock edge that samples the press. Its slot enable turns on, and the enables always form a contiguous run starting at slot 0.
- R6: Once six digits are stored, further digits are ignored. The stored digits neither shift nor change.
- R7: 'A', 'B', 'C', 'D' and '*' leave the buffer, the enables and the LED unchanged.
- R8: A '#' press with six stored digits equal to the secret turns the LED on. Every '#' press clears the buffer and all enables.
- R9: A '#' press with fewer than six digits, or with six digits that differ from the secret, turns the LED off.
- R10: The LED changes only on a '#' press and otherwise holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| key_valid_i | input | 1 | Scanner reports a pressed key |
| key_row_i | input | 2 | Row index of the reported key |
| key_col_i | input | 2 | Column index of the reported key |
| led_o | output | 1 | Result of the most recent submission (1 = match) |
| disp_digits_o | output | 24 | BCD digits entered, slot k in bits 4k+3..4k |
| disp_en_o | output | 6 | Per-slot enable, bit k set when slot k holds a digit |

## Verification
The assertions assume that the row and column inputs are meaningful only while valid is high. They also assume the scanner changes its inputs only between clock edges, one key at a time, so that comparing a sample with the previous one tells a new press from a held one. The stimulus changes inputs only on the falling clock edge. It holds keys for several cycles, releases them, and switches keys without releasing, and no key is pressed until the internal reset release has completed.

// File: rtl/pin_entry_pkg.sv
package pin_entry_pkg;

  typedef enum logic [1:0] {
    SYM_DIGIT  = 2'd0,
    SYM_SUBMIT = 2'd1,
    SYM_OTHER  = 2'd2
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e  kind;
    logic [3:0] value;
  } key_sym_t;

  // Row-major 4x4 layout: 3x3 digit block, zero and '#' on the last row.
  function automatic key_sym_t decode_key(input logic [1:0] row, input logic [1:0] col);
    key_sym_t s;
    s.kind  = SYM_OTHER;
    s.value = 4'd0;
    if (row != 2'd3 && col != 2'd3) begin
      s.kind  = SYM_DIGIT;
      s.value = {2'b00, row} * 4'd3 + {2'b00, col} + 4'd1;
    end else if (row == 2'd3 && col == 2'd1) begin
      s.kind  = SYM_DIGIT;
      s.value = 4'd0;
    end else if (row == 2'd3 && col == 2'd2) begin
      s.kind  = SYM_SUBMIT;
    end
    return s;
  endfunction

endpackage

// File: rtl/pin_rst_sync.sv
module pin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/pin_key_edge.sv
module pin_key_edge #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] row_i,
  input  logic [IDX_W-1:0] col_i,
  output logic             press_o
);
  logic             valid_q, valid_d;
  logic [IDX_W-1:0] row_q, row_d, col_q, col_d;

  always_comb begin
    valid_d = valid_i;
    row_d   = row_i;
    col_d   = col_i;
    press_o = valid_i && (!valid_q || row_i != row_q || col_i != col_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      valid_q <= valid_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end
endmodule

// File: rtl/pin_digit_store.sv
module pin_digit_store #(
  parameter int unsigned N_DIGITS = 6,
  parameter int unsigned DIGIT_W  = 4,
  localparam int unsigned CNT_W   = $clog2(N_DIGITS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_i,
  input  logic [DIGIT_W-1:0]          value_i,
  input  logic                        clear_i,
  output logic [N_DIGITS*DIGIT_W-1:0] digits_o,
  output logic [N_DIGITS-1:0]         en_o,
  output logic                        full_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             accept;

  always_comb begin
    full_o  = (count_q == CNT_W'(N_DIGITS));
    accept  = push_i && !full_o;
    count_d = count_q;
    if (clear_i)     count_d = '0;
    else if (accept) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_slot
    logic [DIGIT_W-1:0] slot_q, slot_d;
    logic               slot_we;

    always_comb begin
      slot_we = clear_i || (accept && count_q == CNT_W'(i));
      slot_d  = clear_i ? '0 : value_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= slot_d;
    end

    assign digits_o[i*DIGIT_W +: DIGIT_W] = slot_q;
    assign en_o[i] = (count_q > CNT_W'(i));
  end
endmodule

// File: rtl/pin_match_led.sv
module pin_match_led #(
  parameter int unsigned             CODE_W = 24,
  parameter logic [CODE_W-1:0]       SECRET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              submit_i,
  input  logic              full_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              led_o
);
  logic led_q, led_d;

  always_comb begin
    led_d = led_q;
    if (submit_i) led_d = full_i && (code_i == SECRET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_d;
  end

  assign led_o = led_q;
endmodule

// File: rtl/pin_entry_checker.sv
module pin_entry_checker #(
  parameter int unsigned N_DIGITS = 6,
  parameter int unsigned DIGIT_W  = 4,
  localparam int unsigned CODE_W  = N_DIGITS * DIGIT_W,
  parameter logic [CODE_W-1:0] SECRET = 24'h654321
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid_i,
  input  logic [1:0]        key_row_i,
  input  logic [1:0]        key_col_i,
  output logic              led_o,
  output logic [CODE_W-1:0] disp_digits_o,
  output logic [N_DIGITS-1:0] disp_en_o
);
  import pin_entry_pkg::*;

  logic     rst_n_sync;
  logic     press;
  logic     full;
  key_sym_t sym;
  logic     push_digit, submit;

  pin_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_sync)
  );

  pin_key_edge #(.IDX_W(2)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .valid_i (key_valid_i),
    .row_i   (key_row_i),
    .col_i   (key_col_i),
    .press_o (press)
  );

  always_comb begin
    sym        = decode_key(key_row_i, key_col_i);
    push_digit = press && (sym.kind == SYM_DIGIT);
    submit     = press && (sym.kind == SYM_SUBMIT);
  end

  pin_digit_store #(.N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .push_i   (push_digit),
    .value_i  (sym.value[DIGIT_W-1:0]),
    .clear_i  (submit),
    .digits_o (disp_digits_o),
    .en_o     (disp_en_o),
    .full_o   (full)
  );

  pin_match_led #(.CODE_W(CODE_W), .SECRET(SECRET)) u_match (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .submit_i (submit),
    .full_i   (full),
    .code_i   (disp_digits_o),
    .led_o    (led_o)
  );
endmodule

// File: rtl/pin_entry_checker_chk.sv
module pin_entry_checker_chk #(
  parameter int unsigned N_DIGITS = 6,
  parameter int unsigned DIGIT_W  = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        valid,
  input logic [1:0]                  row,
  input logic [1:0]                  col,
  input logic                        led,
  input logic [N_DIGITS*DIGIT_W-1:0] digits,
  input logic [N_DIGITS-1:0]         en
);
  logic [N_DIGITS-1:0] en_inc;
  logic is_hash, is_letter, is_digit, fresh;

  always_comb begin
    en_inc    = en + 1'b1;
    is_hash   = (row == 2'd3) && (col == 2'd2);
    is_letter = (col == 2'd3) || (row == 2'd3 && col == 2'd0);
    is_digit  = !is_hash && !is_letter;
  end

  // R5: enables form a contiguous run from slot 0
  p_enables_contiguous_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_inc & en) == '0);

  // R3: same key held across edges changes nothing
  p_held_key_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && row == $past(row) && col == $past(col))
      |=> ($stable(en) && $stable(digits) && $stable(led)));

  // R7: letter and star keys are ignored
  p_letter_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_letter) |=> ($stable(en) && $stable(digits) && $stable(led)));

  // R8: a new '#' press empties the buffer
  p_submit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$past(valid) && is_hash) |=> (en == '0));

  // R10: LED moves only on '#'
  p_led_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && is_hash) |=> $stable(led));

  // R6: a full buffer does not change on a digit
  p_full_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_digit && (&en)) |=> ($stable(digits) && (&en)));

  // R5: a fresh digit with room grows the entry by one slot
  p_digit_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$past(valid) && is_digit && !(&en))
      |=> ($countones(en) == $countones($past(en)) + 1));
endmodule

bind pin_entry_checker pin_entry_checker_chk #(.N_DIGITS(N_DIGITS), .DIGIT_W(DIGIT_W)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .valid  (key_valid_i),
  .row    (key_row_i),
  .col    (key_col_i),
  .led    (led_o),
  .digits (disp_digits_o),
  .en     (disp_en_o)
);

// File: tb/test_pin_entry_checker.sv
module test_pin_entry_checker;
  localparam int N = 6;

  logic        clk;
  logic        rst_n;
  logic        kv;
  logic [1:0]  kr, kc;
  logic        led;
  logic [23:0] digs;
  logic [5:0]  en;

  pin_entry_checker i_pin_entry_checker (
    .clk(clk), .rst_n(rst_n), .key_valid_i(kv), .key_row_i(kr), .key_col_i(kc),
    .led_o(led), .disp_digits_o(digs), .disp_en_o(en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int          due;
    logic        led;
    logic [23:0] digs;
    logic [5:0]  en;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0, fails = 0;
  logic [3:0]  m_slot [N];
  int   m_cnt;
  logic m_led;
  logic p_v;
  logic [1:0] p_r, p_c;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (led !== e.led || digs !== e.digs || en !== e.en) begin
        fails++;
        $display("FAIL %s: led=%b digs=%h en=%b expected led=%b digs=%h en=%b",
                 e.req, led, digs, en, e.led, e.digs, e.en);
      end
    end
  end

  function automatic logic [23:0] pack_model();
    logic [23:0] v = '0;
    for (int i = 0; i < N; i++) v[i*4 +: 4] = m_slot[i];
    return v;
  endfunction

  task automatic expect_now(string req);
    exp_t e;
    e.due = cyc + 1; e.led = m_led; e.digs = pack_model();
    e.en = 6'((1 << m_cnt) - 1); e.req = req;
    exp_q.push_back(e);
  endtask

  // Driver: one cycle of scanner output, model updated from the requirements
  task automatic step(logic v, logic [1:0] r, logic [1:0] c, string req);
    logic press;
    @(negedge clk);
    kv = v; kr = r; kc = c;
    press = v && (!p_v || r != p_r || c != p_c);
    if (press) begin
      if (r == 3 && c == 2) begin
        m_led = (m_cnt == N) && (m_slot[0] == 1) && (m_slot[1] == 2) && (m_slot[2] == 3)
                && (m_slot[3] == 4) && (m_slot[4] == 5) && (m_slot[5] == 6);
        m_cnt = 0;
        for (int i = 0; i < N; i++) m_slot[i] = 0;
      end else if (c != 3 && !(r == 3 && c == 0)) begin
        if (m_cnt < N) begin
          m_slot[m_cnt] = (r == 3) ? 4'd0 : 4'(r * 3 + c + 1);
          m_cnt++;
        end
      end
    end
    p_v = v; p_r = r; p_c = c;
    expect_now(req);
  endtask

  task automatic tap(logic [1:0] r, logic [1:0] c, string req);
    step(1'b1, r, c, req);
    step(1'b1, r, c, req);
    step(1'b0, r, c, req);
  endtask

  task automatic digit(int d, string req);
    if (d == 0) tap(2'd3, 2'd1, req);
    else        tap(2'((d - 1) / 3), 2'((d - 1) % 3), req);
  endtask

  task automatic hash(string req);
    tap(2'd3, 2'd2, req);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    kv = 0; kr = 0; kc = 0;
    p_v = 0; p_r = 0; p_c = 0;
    m_cnt = 0; m_led = 0;
    for (int i = 0; i < N; i++) m_slot[i] = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (led !== 0 || en !== 0 || digs !== 0) begin
      fails++;
      $display("FAIL R1: led=%b en=%b digs=%h expected 0 0 0", led, en, digs);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    checks++;
    if (led !== 0 || en !== 0 || digs !== 0) begin
      fails++;
      $display("FAIL R1: after release led=%b en=%b digs=%h expected 0 0 0", led, en, digs);
    end

    // R2 R5: digit mapping, including 0 and 9
    digit(7, "R2"); digit(8, "R2"); digit(9, "R2"); digit(0, "R2");
    hash("R9");   // short entry -> off
    // R3: long hold counts once
    for (int k = 0; k < 8; k++) step(1'b1, 2'd0, 2'd0, "R3");
    step(1'b0, 2'd0, 2'd0, "R3");
    // R4: identity change without release
    step(1'b1, 2'd0, 2'd1, "R4");
    step(1'b1, 2'd0, 2'd2, "R4");
    step(1'b1, 2'd0, 2'd2, "R4");
    step(1'b0, 2'd0, 2'd2, "R4");
    // R7: letters and star
    tap(2'd0, 2'd3, "R7"); tap(2'd3, 2'd0, "R7"); tap(2'd3, 2'd3, "R7");
    digit(4, "R5"); digit(5, "R5"); digit(6, "R5");
    // R6: extra digits ignored
    digit(9, "R6"); digit(0, "R6");
    hash("R8");   // 123456 -> on
    // R10: letters and digits keep the LED
    tap(2'd2, 2'd3, "R10"); digit(3, "R10");
    hash("R9");   // short -> off
    for (int d = 1; d <= 5; d++) digit(d, "R9");
    digit(7, "R9");
    hash("R9");   // wrong sixth digit -> off
    for (int d = 1; d <= 6; d++) digit(d, "R8");
    hash("R8");
    tap(2'd1, 2'd3, "R10");
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule